// File: doc/BRIEF.md
# Translation Lookaside Buffer with Reference-Bit Replacement

This block holds a handful of recent virtual-to-physical page translations and answers lookups in the same cycle. A requester presents a 20-bit virtual page number. If a valid entry carries that page number, the block raises a hit and drives the 18-bit physical page number. That number, joined with the unchanged 12-bit page offset, forms a 30-bit physical address. If no valid entry matches, the block raises a miss. The requester then resolves the translation elsewhere and returns it through the fill port. The block never walks page tables and never raises exceptions.

Every entry carries three flags: valid, referenced and dirty. The referenced flag is set whenever the entry is used. A free-running period counter clears all referenced flags together, which gives a cheap approximation of least-recently-used replacement when a fill needs a slot. The dirty flag records that a write has hit the page. It is reported with each hit so the requester can plan a copy back. A single flush input invalidates the whole table in one cycle.

Top module: `xlt_tlb`

## Requirements
- R1: After reset every entry is invalid, so any lookup reports a miss and no hit.
- R2: When `lk_valid` is high, `lk_hit` rises in the same cycle if a valid entry's page number equals `lk_vpn`, and `lk_ppn` then shows that entry's physical page. Otherwise `lk_miss` rises. `lk_hit` and `lk_miss` are never high together.
- R3: A lookup hit with `lk_write` high sets that entry's dirty flag from the next cycle on. `lk_dirty` shows the dirty flag of the entry that hits.
- R4: A fill stores the supplied page number, physical page and dirty value in one entry, marks it valid, and is visible to lookups from the next cycle.
- R5: If the fill page number already sits in a valid entry, that entry is overwritten, so no page number is ever held twice.
- R6: Otherwise a fill takes the lowest-indexed invalid entry.
- R7: With no invalid entry, a fill takes the lowest-indexed entry whose referenced flag is clear.
- R8: With every entry valid and referenced, a fill takes entry 0.
- R9: A lookup hit and a fill each set the referenced flag of the entry they touch.
- R10: On every REF_PERIOD-th cycle after reset, all referenced flags are cleared, except the flag of an entry hit or filled in that same cycle.
- R11: A flush clears every valid, referenced and dirty flag in one cycle and overrides a fill or hit issued in the same cycle.
- R12: With `lk_valid` low, neither `lk_hit` nor `lk_miss` is raised, whatever `lk_vpn` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request present |
| lk_write | input | 1 | Lookup is for a store; sets dirty on a hit |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_hit | output | 1 | Valid matching entry found |
| lk_miss | output | 1 | Request present but no match |
| lk_ppn | output | PPN_W | Physical page number of the hit entry, zero otherwise |
| lk_dirty | output | 1 | Dirty flag of the hit entry |
| fill_en | input | 1 | Install a translation this cycle |
| fill_vpn | input | VPN_W | Page number of the installed translation |
| fill_ppn | input | PPN_W | Physical page of the installed translation |
| fill_dirty | input | 1 | Initial dirty flag of the installed translation |
| flush | input | 1 | Invalidate all entries |

## Verification
The bench builds the block with ENTRIES=4 and REF_PERIOD=16, keeping the 20-bit and 18-bit page widths. Four entries let a few fills reach the full-table cases quickly, where the referenced flags and the entry-0 fallback decide the victim. A 16-cycle clearing period lets several clearing events fall inside a short run, including ones that coincide with hits and fills. A randomized phase over a small pool of page numbers then mixes refills, write hits and flushes against the behavioural model.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
  localparam int unsigned DEF_VPN_W   = 20;
  localparam int unsigned DEF_PPN_W   = 18;
  localparam int unsigned DEF_ENTRIES = 16;
  localparam int unsigned DEF_PERIOD  = 256;

  // Source of the slot chosen for an incoming fill, in priority order.
  typedef enum logic [1:0] {
    PICK_SAME = 2'd0,
    PICK_FREE = 2'd1,
    PICK_COLD = 2'd2,
    PICK_ZERO = 2'd3
  } pick_t;
endpackage

// File: rtl/xlt_cam.sv
module xlt_cam #(
  parameter int unsigned VPN_W   = xlt_pkg::DEF_VPN_W,
  parameter int unsigned ENTRIES = xlt_pkg::DEF_ENTRIES,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0] vld,
  input  logic [VPN_W-1:0]   tags [ENTRIES],
  input  logic [VPN_W-1:0]   key,
  output logic [ENTRIES-1:0] match,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);
  // One comparator per entry, all in parallel.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = vld[g] && (tags[g] == key);
  end

  assign any = |match;

  always_comb begin
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/xlt_victim.sv
module xlt_victim #(
  parameter int unsigned ENTRIES = xlt_pkg::DEF_ENTRIES,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] vld,
  input  logic [ENTRIES-1:0] refb,
  input  logic               same_hit,
  input  logic [IDX_W-1:0]   same_idx,
  output logic [IDX_W-1:0]   idx
);
  import xlt_pkg::*;

  logic [ENTRIES-1:0] free_v;
  logic [ENTRIES-1:0] cold_v;
  pick_t              pick;

  assign free_v = ~vld;
  assign cold_v = vld & ~refb;

  function automatic logic [IDX_W-1:0] lowest(input logic [ENTRIES-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  always_comb begin
    if (same_hit)      pick = PICK_SAME;
    else if (|free_v)  pick = PICK_FREE;
    else if (|cold_v)  pick = PICK_COLD;
    else               pick = PICK_ZERO;
  end

  always_comb begin
    unique case (pick)
      PICK_SAME: idx = same_idx;
      PICK_FREE: idx = lowest(free_v);
      PICK_COLD: idx = lowest(cold_v);
      default:   idx = '0;
    endcase
  end

  // R6: with a free slot available, the chosen slot is not valid.
  assert_free_slot_R6: assert property (@(posedge clk) disable iff (rst)
    (!same_hit && (|free_v)) |-> !vld[idx]);

  // R7: with the table full, a clear referenced flag is preferred.
  assert_cold_slot_R7: assert property (@(posedge clk) disable iff (rst)
    (!same_hit && !(|free_v) && (|cold_v)) |-> !refb[idx]);
endmodule

// File: rtl/xlt_ager.sv
module xlt_ager #(
  parameter int unsigned PERIOD = xlt_pkg::DEF_PERIOD,
  localparam int unsigned CW    = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == CW'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/xlt_tlb.sv
module xlt_tlb #(
  parameter int unsigned VPN_W      = xlt_pkg::DEF_VPN_W,
  parameter int unsigned PPN_W      = xlt_pkg::DEF_PPN_W,
  parameter int unsigned ENTRIES    = xlt_pkg::DEF_ENTRIES,
  parameter int unsigned REF_PERIOD = xlt_pkg::DEF_PERIOD
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic             lk_write,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic             lk_miss,
  output logic [PPN_W-1:0] lk_ppn,
  output logic             lk_dirty,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_dirty,
  input  logic             flush
);
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  // Flag state, reset.
  logic [ENTRIES-1:0] vld_q, ref_q, dirty_q;
  // Payload arrays, no reset.
  logic [VPN_W-1:0]   tag_q [ENTRIES];
  logic [PPN_W-1:0]   pfn_q [ENTRIES];

  logic [ENTRIES-1:0] lk_match, fl_match;
  logic               lk_any, fl_any;
  logic [IDX_W-1:0]   lk_idx, fl_idx, vic_idx;
  logic               tick;
  logic [ENTRIES-1:0] hit_oh, fill_oh, keep_oh;

  xlt_cam #(.VPN_W(VPN_W), .ENTRIES(ENTRIES)) u_cam_lk (
    .vld(vld_q), .tags(tag_q), .key(lk_vpn),
    .match(lk_match), .any(lk_any), .idx(lk_idx)
  );

  xlt_cam #(.VPN_W(VPN_W), .ENTRIES(ENTRIES)) u_cam_fill (
    .vld(vld_q), .tags(tag_q), .key(fill_vpn),
    .match(fl_match), .any(fl_any), .idx(fl_idx)
  );

  xlt_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk(clk), .rst(rst), .vld(vld_q), .refb(ref_q),
    .same_hit(fl_any), .same_idx(fl_idx), .idx(vic_idx)
  );

  xlt_ager #(.PERIOD(REF_PERIOD)) u_ager (
    .clk(clk), .rst(rst), .tick(tick)
  );

  // Lookup answers in the same cycle.
  assign lk_hit   = lk_valid && lk_any;
  assign lk_miss  = lk_valid && !lk_any;
  assign lk_ppn   = lk_hit ? pfn_q[lk_idx] : '0;
  assign lk_dirty = lk_hit && dirty_q[lk_idx];

  assign hit_oh  = lk_hit  ? (ENTRIES'(1) << lk_idx)  : '0;
  assign fill_oh = fill_en ? (ENTRIES'(1) << vic_idx) : '0;
  assign keep_oh = hit_oh | fill_oh;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      vld_q   <= '0;
      ref_q   <= '0;
      dirty_q <= '0;
    end else begin
      vld_q   <= vld_q | fill_oh;
      ref_q   <= (tick ? '0 : ref_q) | keep_oh;
      dirty_q <= ((dirty_q | (lk_write ? hit_oh : '0)) & ~fill_oh)
               | (fill_dirty ? fill_oh : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en && !flush) begin
      tag_q[vic_idx] <= fill_vpn;
      pfn_q[vic_idx] <= fill_ppn;
    end
  end

  // R5: refills reuse the matching slot, so at most one entry matches.
  assert_single_match_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_match));

  // R2: hit and miss are exclusive.
  assert_hit_or_miss_R2: assert property (@(posedge clk) disable iff (rst)
    !(lk_hit && lk_miss));

  // R11: a flush leaves the table empty.
  assert_flush_empty_R11: assert property (@(posedge clk) disable iff (rst)
    flush |=> (vld_q == '0));

  // R4: a fill lands as a valid entry holding the supplied page number.
  assert_fill_lands_R4: assert property (@(posedge clk) disable iff (rst)
    (fill_en && !flush) |=> (vld_q[$past(vic_idx)] && (tag_q[$past(vic_idx)] == $past(fill_vpn))));

  // R10: a clearing cycle keeps only the flags touched in that cycle.
  assert_age_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (tick && !flush) |=> ((ref_q & ~$past(keep_oh)) == '0));

  // R3: a write hit marks the page dirty unless a fill replaces it.
  assert_write_dirty_R3: assert property (@(posedge clk) disable iff (rst)
    (lk_hit && lk_write && !flush && !fill_en) |=> dirty_q[$past(lk_idx)]);
endmodule

// File: tb/tb_xlt_tlb.sv
`timescale 1ns/1ps
module tb_xlt_tlb;
  localparam int N  = 4;
  localparam int P  = 16;
  localparam int VW = 20;
  localparam int PW = 18;

  logic clk = 1'b0;
  logic rst, lk_valid, lk_write, fill_en, fill_dirty, flush;
  logic [VW-1:0] lk_vpn, fill_vpn;
  logic [PW-1:0] fill_ppn;
  logic lk_hit, lk_miss, lk_dirty;
  logic [PW-1:0] lk_ppn;

  always #10 clk = ~clk;

  xlt_tlb #(.VPN_W(VW), .PPN_W(PW), .ENTRIES(N), .REF_PERIOD(P)) dut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_write(lk_write),
    .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_ppn(lk_ppn),
    .lk_dirty(lk_dirty), .fill_en(fill_en), .fill_vpn(fill_vpn),
    .fill_ppn(fill_ppn), .fill_dirty(fill_dirty), .flush(flush)
  );

  // Behavioural reference model.
  bit            m_vld [N];
  bit            m_ref [N];
  bit            m_drt [N];
  logic [VW-1:0] m_tag [N];
  logic [PW-1:0] m_pfn [N];
  int            m_cnt;

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input string req, input bit r, input bit lv, input bit lw,
                      input logic [VW-1:0] lvpn, input bit fe,
                      input logic [VW-1:0] fv, input logic [PW-1:0] fp,
                      input bit fd, input bit fl);
    int h, v;
    bit eh, tk;
    rst = r; lk_valid = lv; lk_write = lw; lk_vpn = lvpn;
    fill_en = fe; fill_vpn = fv; fill_ppn = fp; fill_dirty = fd; flush = fl;
    #5;
    h = -1;
    for (int i = 0; i < N; i++) if (m_vld[i] && m_tag[i] == lvpn) h = i;
    eh = lv && (h >= 0);
    chk(req, "hit", lk_hit, eh);
    chk(req, "miss", lk_miss, lv && !eh);
    if (eh) begin
      chk(req, "ppn", lk_ppn, m_pfn[h]);
      chk(req, "dirty", lk_dirty, m_drt[h]);
    end
    v = -1;
    for (int i = 0; i < N; i++) if (m_vld[i] && m_tag[i] == fv) v = i;
    if (v < 0) for (int i = N - 1; i >= 0; i--) if (!m_vld[i]) v = i;
    if (v < 0) for (int i = N - 1; i >= 0; i--) if (!m_ref[i]) v = i;
    if (v < 0) v = 0;
    @(posedge clk);
    if (r || fl) begin
      for (int i = 0; i < N; i++) begin m_vld[i] = 0; m_ref[i] = 0; m_drt[i] = 0; end
      if (r) m_cnt = 0;
      else m_cnt = (m_cnt == P - 1) ? 0 : m_cnt + 1;
    end else begin
      tk = (m_cnt == P - 1);
      m_cnt = tk ? 0 : m_cnt + 1;
      if (tk) for (int i = 0; i < N; i++) m_ref[i] = 0;
      if (eh) begin
        m_ref[h] = 1;
        if (lw) m_drt[h] = 1;
      end
      if (fe) begin
        m_vld[v] = 1; m_ref[v] = 1; m_drt[v] = fd;
        m_tag[v] = fv; m_pfn[v] = fp;
      end
    end
    @(negedge clk);
  endtask

  task automatic look(input string req, input logic [VW-1:0] a, input bit w);
    step(req, 0, 1, w, a, 0, '0, '0, 0, 0);
  endtask

  task automatic put(input string req, input logic [VW-1:0] a,
                     input logic [PW-1:0] p, input bit d);
    step(req, 0, 0, 0, '0, 1, a, p, d, 0);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_vld[i] = 0; m_ref[i] = 0; m_drt[i] = 0; m_tag[i] = '0; m_pfn[i] = '0;
    end
    m_cnt = 0;
    rst = 1; lk_valid = 0; lk_write = 0; lk_vpn = '0;
    fill_en = 0; fill_vpn = '0; fill_ppn = '0; fill_dirty = 0; flush = 0;
    @(negedge clk);
    step("R1", 1, 1, 0, 20'h10, 0, '0, '0, 0, 0);
    step("R1", 1, 0, 0, '0, 0, '0, '0, 0, 0);
    look("R1", 20'h10, 0);
    look("R1", 20'h0, 0);
    // R6: empty table fills slots in index order
    put("R6", 20'h10, 18'h101, 0);
    put("R6", 20'h11, 18'h111, 0);
    put("R6", 20'h12, 18'h121, 0);
    put("R6", 20'h13, 18'h131, 0);
    look("R4", 20'h10, 0);
    look("R4", 20'h11, 0);
    look("R4", 20'h12, 0);
    look("R4", 20'h13, 0);
    // R12: no request, matching page number
    step("R12", 0, 0, 0, 20'h12, 0, '0, '0, 0, 0);
    // R8: all referenced, slot 0 replaced
    put("R8", 20'h20, 18'h201, 0);
    look("R8", 20'h20, 0);
    look("R8", 20'h10, 0);
    // R10: pass a clearing event
    for (int i = 0; i < 16; i++) step("R10", 0, 0, 0, '0, 0, '0, '0, 0, 0);
    look("R9", 20'h20, 0);
    put("R7", 20'h30, 18'h301, 0);
    look("R7", 20'h30, 0);
    put("R7", 20'h31, 18'h311, 0);
    look("R7", 20'h31, 0);
    look("R3", 20'h31, 1);
    look("R3", 20'h31, 0);
    put("R5", 20'h31, 18'h3ff, 0);
    look("R5", 20'h31, 0);
    put("R4", 20'h40, 18'h401, 1);
    look("R4", 20'h40, 0);
    // R10: hits straddling clearing events
    for (int i = 0; i < 20; i++) look("R10", 20'h40, 0);
    put("R10", 20'h41, 18'h411, 0);
    look("R10", 20'h41, 0);
    look("R10", 20'h40, 0);
    // R11: flush, then flush with a fill
    step("R11", 0, 1, 1, 20'h40, 0, '0, '0, 0, 1);
    look("R11", 20'h40, 0);
    step("R11", 0, 0, 0, '0, 1, 20'h50, 18'h501, 0, 1);
    look("R11", 20'h50, 0);
    // R2: randomized mix
    for (int i = 0; i < 400; i++) begin
      int k;
      k = $urandom_range(0, 99);
      if (k < 3)
        step("R11", 0, 1, 0, 20'h60 + 20'($urandom_range(0, 6)), 0, '0, '0, 0, 1);
      else if (k < 35)
        step("R5", 0, $urandom_range(0, 1), 0, 20'h60 + 20'($urandom_range(0, 6)), 1,
             20'h60 + 20'($urandom_range(0, 6)), 18'($urandom_range(0, 4095)),
             $urandom_range(0, 1), 0);
      else
        look("R2", 20'h60 + 20'($urandom_range(0, 6)), $urandom_range(0, 1));
    end
    finish_run();
  end
endmodule